// File: doc/BRIEF.md
# Counting Semaphore and Event Flag Bank with Blocking Wait

This block keeps a bank of counting semaphores and a bank of single-bit event flags behind a plain register write and read port. The byte address picks both the target and the operation. One window holds the event words. Four further windows each cover every semaphore: one reads the count, one loads a new count, one adds one and one subtracts one. Agents coordinate through this block by posting increments and raising event flags.

A separate request port lets a requester park a waiter on a semaphore with a threshold and a tag. The unit keeps up to `N_WAIT` waiters and checks all of them every cycle. A waiter is released once the semaphore count, after that cycle's register write, is at least its threshold. On release the count is lowered by the threshold. In the next cycle a one-cycle completion pulse carries the waiter's tag and semaphore index toward a notification queue. With the usual threshold of one, each increment frees exactly one waiter.

Top module: `evsem_unit`

## Requirements
- R1: Address bits [12:10] select the window and bits [9:2] the index: 000 events, 100 count read, 101 load, 110 increment, 111 decrement. So semaphore i sits at window base 0x1000/0x1400/0x1800/0x1C00 plus 4*i, and event i at 4*i. A write to any other window changes nothing, and a read there returns 0.
- R2: A load write stores `wr_data` as the count. A read issued with `rd_en` returns `rd_valid`=1 one cycle later, and a read in any of the four semaphore windows returns the count in `rd_data` with no side effect.
- R3: An increment write adds one and ignores `wr_data`. At the all-ones count it leaves the count unchanged.
- R4: A decrement write subtracts one. It is ignored when the count is zero.
- R5: Any write to an event word sets that flag. A read returns the flag in bit 0 (the other bits are 0) and clears it. When a write and a read reach the same event in one cycle, the read returns the old flag and the flag stays set.
- R6: After reset all counts and flags are 0, no waiter is pending, `wait_ready`=1 and `done_valid`=0.
- R7: A wait request is taken in any cycle where `wait_valid` and `wait_ready` are both 1. `wait_ready` is 0 while `N_WAIT` waiters are pending, and a request made then is dropped.
- R8: A pending waiter is released when its semaphore count is at least its threshold. The count is then reduced by the threshold, and `done_valid` pulses for one cycle in the next cycle with the waiter's `done_tag` and `done_sem`.
- R9: A register write to a semaphore takes effect before a release in the same cycle. The release compares against, and subtracts from, the post-write count.
- R10: At most one waiter is released per cycle. Among the eligible waiters, the one taken first is released.
- R11: A waiter is first evaluated in the cycle after it is taken. If the count already meets its threshold, `done_valid` rises two cycles after the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 13 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 13 | Read byte address |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 32 | Read data |
| wait_valid | input | 1 | Wait request present |
| wait_ready | output | 1 | Waiter storage has room |
| wait_sem | input | 8 | Semaphore index to wait on |
| wait_thresh | input | 32 | Release threshold and decrement amount |
| wait_tag | input | 8 | Requester tag returned on completion |
| done_valid | output | 1 | Completion pulse |
| done_sem | output | 8 | Semaphore of the released waiter |
| done_tag | output | 8 | Tag of the released waiter |

## Verification
The bench targets the edges of the counter arithmetic. A wrapping increment would read back zero from an all-ones count, and a decrement that is not ignored at zero would read back all ones. For events, it checks that a read clears the flag and that a simultaneous write survives the read. It also checks that a write to an unmapped window lands nowhere.

On the wait side it tests the same-cycle ordering. A load of 5 under a threshold-3 waiter must leave 2, not 5 or a negative wrap. A design that compared against the pre-write count would miss the release altogether. Two waiters freed by one unit of count must come out in arrival order, one only. A full queue of four must refuse a fifth request and then drain one per cycle. A waiter must not be released in the cycle it is taken.

// File: rtl/evsem_pkg.sv
`timescale 1ns/1ps
package evsem_pkg;

  localparam int ADDR_W = 13;
  localparam int DATA_W = 32;

  // Window code taken from address bits [12:10]
  typedef enum logic [2:0] {
    WIN_EVT  = 3'b000,
    WIN_NONE = 3'b001,
    WIN_RD   = 3'b100,
    WIN_SET  = 3'b101,
    WIN_INC  = 3'b110,
    WIN_DEC  = 3'b111
  } win_e;

  function automatic win_e win_of(input logic en, input logic [ADDR_W-1:0] a);
    if (!en) return WIN_NONE;
    case (a[12:10])
      3'b000:  return WIN_EVT;
      3'b100:  return WIN_RD;
      3'b101:  return WIN_SET;
      3'b110:  return WIN_INC;
      3'b111:  return WIN_DEC;
      default: return WIN_NONE;
    endcase
  endfunction

  function automatic logic is_sem_win(input win_e w);
    return (w == WIN_RD) || (w == WIN_SET) || (w == WIN_INC) || (w == WIN_DEC);
  endfunction

endpackage

// File: rtl/evsem_decode.sv
`timescale 1ns/1ps
module evsem_decode
  import evsem_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int EIDX_W = 8
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output win_e              wr_kind,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [EIDX_W-1:0] wr_eidx,
  output win_e              rd_kind,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [EIDX_W-1:0] rd_eidx
);

  assign wr_kind = win_of(wr_en, wr_addr);
  assign rd_kind = win_of(rd_en, rd_addr);
  assign wr_idx  = wr_addr[2 +: IDX_W];
  assign rd_idx  = rd_addr[2 +: IDX_W];
  assign wr_eidx = wr_addr[2 +: EIDX_W];
  assign rd_eidx = rd_addr[2 +: EIDX_W];

  logic unused_bytelane;
  assign unused_bytelane = ^{wr_addr[1:0], rd_addr[1:0]};

endmodule

// File: rtl/evsem_waitq.sv
`timescale 1ns/1ps
module evsem_waitq #(
  parameter int N      = 4,
  parameter int SEM_W  = 8,
  parameter int THR_W  = 32,
  parameter int TAG_W  = 8,
  localparam int OCC_W = $clog2(N + 1),
  localparam int POS_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq_valid,
  output logic             enq_ready,
  input  logic [SEM_W-1:0] enq_sem,
  input  logic [THR_W-1:0] enq_thr,
  input  logic [TAG_W-1:0] enq_tag,
  output logic [N-1:0]     slot_valid,
  output logic [SEM_W-1:0] slot_sem [N],
  output logic [THR_W-1:0] slot_thr [N],
  input  logic [N-1:0]     elig,
  output logic             rel_valid,
  output logic [SEM_W-1:0] rel_sem,
  output logic [THR_W-1:0] rel_thr,
  output logic [TAG_W-1:0] rel_tag
);

  // Slot 0 always holds the oldest waiter; the queue compacts on release.
  logic [OCC_W-1:0] occ_q, occ_mid, occ_d;
  logic [SEM_W-1:0] sem_q [N], sem_d [N];
  logic [THR_W-1:0] thr_q [N], thr_d [N];
  logic [TAG_W-1:0] tag_q [N], tag_d [N];
  logic [POS_W-1:0] sel_pos;
  logic [N-1:0]     cand, sel_oh;
  logic             enq_fire;

  for (genvar g = 0; g < N; g++) begin : g_slot
    assign slot_valid[g] = (OCC_W'(g) < occ_q);
    assign slot_sem[g]   = sem_q[g];
    assign slot_thr[g]   = thr_q[g];
  end

  assign cand      = slot_valid & elig;
  assign sel_oh    = cand & (~cand + N'(1));
  assign rel_valid = |cand;
  assign enq_ready = (occ_q < OCC_W'(N));
  assign enq_fire  = enq_valid && enq_ready;

  always_comb begin
    sel_pos = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) sel_pos = POS_W'(i);
    end
  end

  assign rel_sem = sem_q[sel_pos];
  assign rel_thr = thr_q[sel_pos];
  assign rel_tag = tag_q[sel_pos];

  always_comb begin
    sem_d   = sem_q;
    thr_d   = thr_q;
    tag_d   = tag_q;
    occ_mid = occ_q - OCC_W'(rel_valid);
    for (int i = 0; i < N - 1; i++) begin
      if (rel_valid && (POS_W'(i) >= sel_pos)) begin
        sem_d[i] = sem_q[i + 1];
        thr_d[i] = thr_q[i + 1];
        tag_d[i] = tag_q[i + 1];
      end
    end
    if (enq_fire) begin
      for (int i = 0; i < N; i++) begin
        if (OCC_W'(i) == occ_mid) begin
          sem_d[i] = enq_sem;
          thr_d[i] = enq_thr;
          tag_d[i] = enq_tag;
        end
      end
    end
    occ_d = occ_mid + OCC_W'(enq_fire);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_q <= '0;
      for (int i = 0; i < N; i++) begin
        sem_q[i] <= '0;
        thr_q[i] <= '0;
        tag_q[i] <= '0;
      end
    end else begin
      occ_q <= occ_d;
      sem_q <= sem_d;
      thr_q <= thr_d;
      tag_q <= tag_d;
    end
  end

  // R10: the isolated lowest candidate is single and matches the chosen slot
  assert_one_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_oh) && (sel_oh[sel_pos] == rel_valid));

  // R7: occupancy never exceeds storage
  assert_occ_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= OCC_W'(N));

  // R7: a full queue with no release stays full and refuses entry
  assert_full_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q == OCC_W'(N)) && !rel_valid |=> (occ_q == OCC_W'(N)) && !enq_ready);

endmodule

// File: rtl/evsem_unit.sv
`timescale 1ns/1ps
module evsem_unit
  import evsem_pkg::*;
#(
  parameter int NUM_SEM = 256,
  parameter int NUM_EVT = 256,
  parameter int CNT_W   = 32,
  parameter int N_WAIT  = 4,
  parameter int TAG_W   = 8,
  localparam int IDX_W  = $clog2(NUM_SEM),
  localparam int EIDX_W = $clog2(NUM_EVT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wait_valid,
  output logic              wait_ready,
  input  logic [IDX_W-1:0]  wait_sem,
  input  logic [CNT_W-1:0]  wait_thresh,
  input  logic [TAG_W-1:0]  wait_tag,
  output logic              done_valid,
  output logic [IDX_W-1:0]  done_sem,
  output logic [TAG_W-1:0]  done_tag
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // Count update for one register write; saturates at both ends.
  function automatic logic [CNT_W-1:0] sem_after_write(
    input win_e k, input logic [CNT_W-1:0] cur, input logic [DATA_W-1:0] d);
    case (k)
      WIN_SET: return d[CNT_W-1:0];
      WIN_INC: return (cur == CNT_MAX) ? cur : cur + CNT_W'(1);
      WIN_DEC: return (cur == '0) ? cur : cur - CNT_W'(1);
      default: return cur;
    endcase
  endfunction

  logic [CNT_W-1:0] cnt_q [NUM_SEM];
  logic [NUM_EVT-1:0] evt_q;

  win_e              wr_kind, rd_kind;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [EIDX_W-1:0] wr_eidx, rd_eidx;

  evsem_decode #(.IDX_W(IDX_W), .EIDX_W(EIDX_W)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_en(rd_en), .rd_addr(rd_addr),
    .wr_kind(wr_kind), .wr_idx(wr_idx), .wr_eidx(wr_eidx),
    .rd_kind(rd_kind), .rd_idx(rd_idx), .rd_eidx(rd_eidx)
  );

  // Named internal events
  logic             wr_mod;     // write changes a semaphore this cycle
  logic [CNT_W-1:0] wr_cur, wr_new;
  assign wr_mod = (wr_kind == WIN_SET) || (wr_kind == WIN_INC) || (wr_kind == WIN_DEC);
  assign wr_cur = cnt_q[wr_idx];
  assign wr_new = sem_after_write(wr_kind, wr_cur, wr_data);

  logic [N_WAIT-1:0] slot_valid, elig;
  logic [IDX_W-1:0]  slot_sem [N_WAIT];
  logic [CNT_W-1:0]  slot_thr [N_WAIT];
  logic              rel_valid;
  logic [IDX_W-1:0]  rel_sem;
  logic [CNT_W-1:0]  rel_thr, rel_base, rel_new;
  logic [TAG_W-1:0]  rel_tag;

  evsem_waitq #(.N(N_WAIT), .SEM_W(IDX_W), .THR_W(CNT_W), .TAG_W(TAG_W)) u_wq (
    .clk(clk), .rst_n(rst_n),
    .enq_valid(wait_valid), .enq_ready(wait_ready),
    .enq_sem(wait_sem), .enq_thr(wait_thresh), .enq_tag(wait_tag),
    .slot_valid(slot_valid), .slot_sem(slot_sem), .slot_thr(slot_thr),
    .elig(elig),
    .rel_valid(rel_valid), .rel_sem(rel_sem), .rel_thr(rel_thr), .rel_tag(rel_tag)
  );

  // Each waiter sees its semaphore as it stands after this cycle's write.
  always_comb begin
    for (int i = 0; i < N_WAIT; i++) begin
      logic [CNT_W-1:0] eff;
      eff = (wr_mod && (wr_idx == slot_sem[i])) ? wr_new : cnt_q[slot_sem[i]];
      elig[i] = slot_valid[i] && (eff >= slot_thr[i]);
    end
  end

  assign rel_base = (wr_mod && (wr_idx == rel_sem)) ? wr_new : cnt_q[rel_sem];
  assign rel_new  = rel_base - rel_thr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SEM; i++) cnt_q[i] <= '0;
    end else begin
      if (wr_mod)    cnt_q[wr_idx]  <= wr_new;
      if (rel_valid) cnt_q[rel_sem] <= rel_new;
    end
  end

  // Events: read clears, a same-cycle write (applied later) wins.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q <= '0;
    end else begin
      if (rd_kind == WIN_EVT) evt_q[rd_eidx] <= 1'b0;
      if (wr_kind == WIN_EVT) evt_q[wr_eidx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= '0;
      if (rd_kind == WIN_EVT)      rd_data[0]         <= evt_q[rd_eidx];
      else if (is_sem_win(rd_kind)) rd_data[CNT_W-1:0] <= cnt_q[rd_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_valid <= 1'b0;
      done_sem   <= '0;
      done_tag   <= '0;
    end else begin
      done_valid <= rel_valid;
      done_sem   <= rel_sem;
      done_tag   <= rel_tag;
    end
  end

  // R8: every release yields a completion pulse with its tag next cycle
  assert_done_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |=> done_valid && (done_tag == $past(rel_tag)) && (done_sem == $past(rel_sem)));

  // R8, R9: a release never underflows the post-write count
  assert_release_ge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> (rel_base >= rel_thr));

  // R4: decrement at zero leaves zero
  assert_dec_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_kind == WIN_DEC) && (wr_cur == '0) |=> (cnt_q[$past(wr_idx)] == '0));

  // R3: increment at the top does not wrap
  assert_inc_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_kind == WIN_INC) && (wr_cur == CNT_MAX) && !(rel_valid && (rel_sem == wr_idx))
    |=> (cnt_q[$past(wr_idx)] == CNT_MAX));

  // R2: read data follows a read strobe by one cycle
  assert_rd_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

endmodule

// File: tb/sim_evsem_unit.sv
`timescale 1ns/1ps
module sim_evsem_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, wait_valid = 1'b0;
  logic [12:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, wait_thresh = '0;
  logic [7:0]  wait_sem = '0, wait_tag = '0;
  logic        rd_valid, wait_ready, done_valid;
  logic [31:0] rd_data;
  logic [7:0]  done_sem, done_tag;

  always #2.5 clk = ~clk;

  evsem_unit u0 (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .wait_valid(wait_valid), .wait_ready(wait_ready), .wait_sem(wait_sem),
    .wait_thresh(wait_thresh), .wait_tag(wait_tag),
    .done_valid(done_valid), .done_sem(done_sem), .done_tag(done_tag)
  );

  int tests = 0, fails = 0;
  int done_n = 0;
  logic [7:0] log_tag [64];
  logic [7:0] log_sem [64];

  always @(negedge clk) begin
    if (rst_n && done_valid && done_n < 64) begin
      log_tag[done_n] = done_tag;
      log_sem[done_n] = done_sem;
      done_n++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Address helpers restated from the window map
  function automatic logic [12:0] a_rd (input int i); return 13'h1000 + 13'(4*i); endfunction
  function automatic logic [12:0] a_set(input int i); return 13'h1400 + 13'(4*i); endfunction
  function automatic logic [12:0] a_inc(input int i); return 13'h1800 + 13'(4*i); endfunction
  function automatic logic [12:0] a_evt(input int i); return 13'(4*i); endfunction

  // All tasks start and end just after a falling edge.
  task automatic bus_wr(input logic [12:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [12:0] a, output logic [31:0] d, output logic v);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data; v = rd_valid;
  endtask

  task automatic rd_chk(input string req, input logic [12:0] a, input logic [31:0] exp);
    logic [31:0] d; logic v;
    bus_rd(a, d, v);
    chk({req, " rd_valid"}, 32'(v), 32'd1);
    chk(req, d, exp);
  endtask

  task automatic post_wait(input int s, input logic [31:0] thr, input logic [7:0] tag);
    wait_valid = 1'b1; wait_sem = 8'(s); wait_thresh = thr; wait_tag = tag;
    @(negedge clk);
    wait_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Vector: {is_read, addr[12:0], data_or_expected[31:0]}
  localparam int NV = 21;
  localparam logic [45:0] VEC [NV] = '{
    {1'b0, 13'h140C, 32'd10},        // R2 load sem3
    {1'b1, 13'h100C, 32'd10},        // R2 read sem3
    {1'b0, 13'h180C, 32'h55},        // R3 inc ignores data
    {1'b1, 13'h100C, 32'd11},        // R3
    {1'b0, 13'h1C0C, 32'h0},         // R4 dec
    {1'b1, 13'h100C, 32'd10},        // R4
    {1'b0, 13'h141C, 32'd0},         // R4 sem7 = 0
    {1'b0, 13'h1C1C, 32'h0},         // R4 dec at zero
    {1'b1, 13'h101C, 32'd0},         // R4 no wrap
    {1'b0, 13'h1424, 32'hFFFFFFFF},  // R3 sem9 = max
    {1'b0, 13'h1824, 32'h0},         // R3 inc at max
    {1'b1, 13'h1024, 32'hFFFFFFFF},  // R3 saturated
    {1'b0, 13'h17FC, 32'd5},         // R1 last semaphore
    {1'b1, 13'h1BFC, 32'd5},         // R1 read via inc window
    {1'b1, 13'h13FC, 32'd5},         // R1 read had no side effect
    {1'b0, 13'h0450, 32'd77},        // R1 unmapped window, idx 20
    {1'b1, 13'h0450, 32'd0},         // R1 unmapped read
    {1'b1, 13'h1050, 32'd0},         // R1 sem20 untouched
    {1'b0, 13'h0050, 32'h0},         // R5 set event 20
    {1'b1, 13'h0050, 32'd1},         // R5 read flag
    {1'b1, 13'h0050, 32'd0}          // R5 cleared by read
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    logic v;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R6 reset state
    chk("R6 done_valid", 32'(done_valid), 32'd0);
    chk("R6 wait_ready", 32'(wait_ready), 32'd1);
    chk("R6 rd_valid", 32'(rd_valid), 32'd0);
    rd_chk("R6 count", a_rd(0), 32'd0);
    rd_chk("R6 event", a_evt(0), 32'd0);

    // Register table
    for (int k = 0; k < NV; k++) begin
      if (VEC[k][45]) rd_chk($sformatf("R1-map vec%0d", k), VEC[k][44:32], VEC[k][31:0]);
      else            bus_wr(VEC[k][44:32], VEC[k][31:0]);
    end

    // R5 same-cycle write and read of one event: old flag read, flag kept
    bus_wr(a_evt(30), 32'h0);
    wr_en = 1'b1; wr_addr = a_evt(30); wr_data = '0;
    rd_en = 1'b1; rd_addr = a_evt(30);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R5 read during set", rd_data, 32'd1);
    rd_chk("R5 set survives", a_evt(30), 32'd1);
    rd_chk("R5 now clear", a_evt(30), 32'd0);

    // R8/R9: waiter on zero count, released by the increment's own cycle
    base = done_n;
    post_wait(40, 32'd1, 8'hA1);
    idle(3);
    chk("R8 no early release", 32'(done_n - base), 32'd0);
    bus_wr(a_inc(40), 32'h0);
    idle(1);
    chk("R8 one release", 32'(done_n - base), 32'd1);
    chk("R8 tag", 32'(log_tag[base]), 32'hA1);
    chk("R8 sem", 32'(log_sem[base]), 32'd40);
    rd_chk("R8 count consumed", a_rd(40), 32'd0);

    // R11: count already sufficient; not released in its accept cycle
    bus_wr(a_set(41), 32'd1);
    post_wait(41, 32'd1, 8'hA2);
    chk("R11 not same cycle", 32'(done_valid), 32'd0);
    @(negedge clk);
    chk("R11 pulse next", 32'(done_valid), 32'd1);
    chk("R11 tag", 32'(done_tag), 32'hA2);
    @(negedge clk);
    chk("R8 single pulse", 32'(done_valid), 32'd0);

    // R10: two waiters, one unit of count frees only the older
    base = done_n;
    post_wait(50, 32'd1, 8'hB1);
    post_wait(50, 32'd1, 8'hB2);
    bus_wr(a_set(50), 32'd1);
    idle(3);
    chk("R10 only one", 32'(done_n - base), 32'd1);
    chk("R10 oldest", 32'(log_tag[base]), 32'hB1);
    rd_chk("R10 count", a_rd(50), 32'd0);
    bus_wr(a_inc(50), 32'h0);
    idle(2);
    chk("R10 second", 32'(done_n - base), 32'd2);
    chk("R10 second tag", 32'(log_tag[base + 1]), 32'hB2);

    // R9: threshold 3, load 2 then load 5 -> released, leaves 2
    base = done_n;
    post_wait(60, 32'd3, 8'hC1);
    bus_wr(a_set(60), 32'd2);
    idle(3);
    chk("R9 below threshold", 32'(done_n - base), 32'd0);
    bus_wr(a_set(60), 32'd5);
    idle(2);
    chk("R9 released", 32'(done_n - base), 32'd1);
    rd_chk("R9 load then subtract", a_rd(60), 32'd2);

    // R7/R10: fill storage, refuse extra, drain in order one per cycle
    base = done_n;
    for (int k = 0; k < 4; k++) post_wait(70, 32'd1, 8'(8'hD0 + k));
    chk("R7 full", 32'(wait_ready), 32'd0);
    post_wait(70, 32'd1, 8'hDF);
    bus_wr(a_set(70), 32'd4);
    for (int k = 1; k < 4; k++) begin
      chk($sformatf("R10 drain pulse %0d", k), 32'(done_valid), 32'd1);
      @(negedge clk);
    end
    idle(4);
    chk("R7 dropped request", 32'(done_n - base), 32'd4);
    for (int k = 0; k < 4; k++)
      chk($sformatf("R10 order %0d", k), 32'(log_tag[base + k]), 32'(8'hD0 + k));
    rd_chk("R7 drained count", a_rd(70), 32'd0);
    chk("R7 ready again", 32'(wait_ready), 32'd1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule